// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two page-table entries from memory, one after the other. A client raises a translation request that carries the virtual address and the 20-bit frame number of the root (outer) table. The walker splits the address into a 10-bit outer index, a 10-bit inner index and a 12-bit in-page offset. It reads the outer entry to find the inner table, then reads the inner entry to find the frame. The result is the frame joined to the untouched offset, or a fault that names the level whose entry was not valid.

The walker handles one translation at a time. It signals busy from the moment a request is taken until the cycle its result is shown. Memory reads go out on a simple port. The walker holds a request with its address until the memory grants it, then waits any number of cycles for the read data to come back. Page-table entries carry a frame or table-base number in bits [31:12] and a valid flag in bit 0. Bits [11:1] have no meaning to the walker.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault and mem_req are 0, fault_lvl is 0 and pa is 0.
- R2: The first read of a walk is at address {tr_root, 12'h000} + tr_vaddr[31:22]*4.
- R3: When the outer entry has bit 0 set, the second read is at address {outer_entry[31:12], 12'h000} + tr_vaddr[21:12]*4.
- R4: When the inner entry has bit 0 set, done pulses high for exactly one cycle with fault 0 and fault_lvl 0, and pa = {inner_entry[31:12], tr_vaddr[11:0]}. Entry bits [11:1] do not affect the result.
- R5: When the outer entry has bit 0 clear, no second read is made, and done and fault pulse together for one cycle with fault_lvl = 1 and pa = 0.
- R6: When the inner entry has bit 0 clear, done and fault pulse together for one cycle with fault_lvl = 2 and pa = 0.
- R7: mem_req stays high with mem_addr unchanged until a cycle in which mem_gnt is high, and at most one read is outstanding.
- R8: busy is high from the cycle after a request is taken through the done cycle. A tr_req seen while busy is high, including in the done cycle, is ignored. tr_vaddr and tr_root are sampled only when the request is taken.
- R9: With grant and read data both given with no delay, done rises four clock edges after the edge that takes the request for a full walk, and two edges after it for an outer-level fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_req | input | 1 | Translation request, taken when busy is low |
| tr_vaddr | input | 32 | Virtual address to translate |
| tr_root | input | 20 | Frame number of the outer table |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | High with done when the walk failed |
| fault_lvl | output | 2 | With done: 0 ok, 1 outer entry invalid, 2 inner entry invalid |
| pa | output | 32 | Physical address, valid with done and no fault; else 0 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (page-table entry) |

## Verification
The event that can overlap another is a fresh translation request arriving in the same cycle as the completion pulse of the previous walk, while busy is still high. The bench provokes this by raising tr_req with a new address at the sample point where done is seen, and then holding it. It expects busy to be low in the next cycle, which shows the request was not taken. It expects the request to be taken one cycle later, with the second walk reading its own entries and returning its own address. A second overlap is a grant given in the very cycle mem_req first rises, with data on the next cycle, which is judged by the exact cycle count to done.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tr_req,
  input  logic [VA_W-1:0]  tr_vaddr,
  input  logic [PA_W-OFF_W-1:0] tr_root,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_lvl,
  output logic [PA_W-1:0]  pa,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PA_W-1:0]  mem_rdata
);
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int FN_W  = PA_W - OFF_W;
  localparam int PAD_W = PA_W - IDX_W - 2;

  typedef enum logic [2:0] {IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q;
  logic [FN_W-1:0] base_q;
  logic [FN_W-1:0] frame_q;
  logic [1:0]      err_q;

  wire [IDX_W-1:0] idx_hi = va_q[VA_W-1 -: IDX_W];
  wire [IDX_W-1:0] idx_lo = va_q[OFF_W +: IDX_W];
  wire [IDX_W-1:0] idx    = (st == READ_L1) ? idx_hi : idx_lo;
  wire [PA_W-1:0]  ent_addr = {base_q, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, 2'b00};
  wire             ent_ok = mem_rdata[0];

  assign busy      = (st != IDLE);
  assign mem_req   = (st == READ_L1) || (st == READ_L2);
  assign mem_addr  = mem_req ? ent_addr : '0;
  assign done      = (st == DONE);
  assign fault     = done && (err_q != 2'd0);
  assign fault_lvl = done ? err_q : 2'd0;
  assign pa        = (done && err_q == 2'd0) ? {frame_q, va_q[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      va_q    <= '0;
      base_q  <= '0;
      frame_q <= '0;
      err_q   <= 2'd0;
    end else begin
      case (st)
        IDLE: if (tr_req) begin
          va_q   <= tr_vaddr;
          base_q <= tr_root;
          err_q  <= 2'd0;
          st     <= READ_L1;
        end
        READ_L1: if (mem_gnt) st <= WAIT_L1;
        WAIT_L1: if (mem_rvalid) begin
          if (ent_ok) begin
            base_q <= mem_rdata[PA_W-1:OFF_W];
            st     <= READ_L2;
          end else begin
            err_q <= 2'd1;
            st    <= DONE;
          end
        end
        READ_L2: if (mem_gnt) st <= WAIT_L2;
        WAIT_L2: if (mem_rvalid) begin
          if (ent_ok) frame_q <= mem_rdata[PA_W-1:OFF_W];
          else        err_q   <= 2'd2;
          st <= DONE;
        end
        DONE:    st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R7
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req);

  // R5
  fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done && fault_lvl != 2'd0 && pa == '0);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done && !mem_rvalid);

  // R6
  lvl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT_L2) && mem_rvalid && !mem_rdata[0] |=> fault && fault_lvl == 2'd2);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tr_req = 1'b0;
  logic [31:0] tr_vaddr = '0;
  logic [19:0] tr_root = '0;
  logic        busy, done, fault;
  logic [1:0]  fault_lvl;
  logic [31:0] pa;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .tr_req(tr_req), .tr_vaddr(tr_vaddr), .tr_root(tr_root),
    .busy(busy), .done(done), .fault(fault), .fault_lvl(fault_lvl), .pa(pa),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  int glat = 0, rlat = 0, phase = 0, cnt = 0, n_rd = 0;
  logic [31:0] log_a [64];
  logic [31:0] pend_a;

  always @(negedge clk) begin
    mem_gnt = 1'b0;
    mem_rvalid = 1'b0;
    if (phase == 0) begin
      if (mem_req) begin
        if (cnt >= glat) begin
          mem_gnt = 1'b1;
          pend_a = mem_addr;
          log_a[n_rd % 64] = mem_addr;
          n_rd++;
          phase = 1;
          cnt = 0;
        end else cnt++;
      end
    end else if (phase == 1) begin
      phase = 2;
    end
    if (phase == 2 && !mem_gnt) begin
      if (cnt >= rlat) begin
        mem_rvalid = 1'b1;
        mem_rdata = rd(pend_a);
        phase = 0;
        cnt = 0;
      end else cnt++;
    end
  end

  localparam logic [31:0] VA_T [NV] = '{32'h00405123, 32'h007FFFFF, 32'hFFC00000,
                                         32'h00800456, 32'h00406789, 32'h00005ABC, 32'h40000000};
  localparam logic [19:0] RT_T [NV] = '{20'h00010, 20'h00010, 20'h00010,
                                         20'h00010, 20'h00010, 20'h00050, 20'h00010};
  localparam logic [31:0] PA_T [NV] = '{32'hABCDE123, 32'h12345FFF, 32'hFFFFF000,
                                         32'h0, 32'h0, 32'hABCDEABC, 32'h0};
  localparam logic [1:0]  FL_T [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1};
  localparam int          GL_T [NV] = '{0, 2, 1, 0, 3, 1, 0};
  localparam int          RL_T [NV] = '{0, 3, 0, 0, 4, 2, 1};

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 1000);
  endtask

  task automatic check_walk(input logic [31:0] va, input logic [19:0] rt, input logic [31:0] exp_pa,
                            input logic [1:0] exp_fl, input int first);
    logic [31:0] a1, a2, e1;
    a1 = {rt, 12'h000} + {20'h0, va[31:22], 2'b00};
    chk("R2 outer entry address", log_a[first % 64], a1);
    e1 = rd(a1);
    if (exp_fl == 2'd1) begin
      chk("R5 no inner read after outer fault", n_rd - first, 1);
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      chk("R3 inner entry address", log_a[(first + 1) % 64], a2);
    end
    chk(exp_fl == 2'd0 ? "R4 pa" : (exp_fl == 2'd1 ? "R5 pa" : "R6 pa"), pa, exp_pa);
    chk(exp_fl == 2'd0 ? "R4 fault" : "R5/R6 fault", {31'h0, fault}, {31'h0, exp_fl != 2'd0});
    chk(exp_fl == 2'd2 ? "R6 fault_lvl" : (exp_fl == 2'd1 ? "R5 fault_lvl" : "R4 fault_lvl"),
        {30'h0, fault_lvl}, {30'h0, exp_fl});
  endtask

  task automatic start(input logic [31:0] va, input logic [19:0] rt);
    @(negedge clk);
    n_rd = 0;
    tr_req = 1'b1;
    tr_vaddr = va;
    tr_root = rt;
    @(negedge clk);
    tr_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int base;
    mem[32'h00010004] = 32'h00020FF1;
    mem[32'h00010FFC] = 32'h00030001;
    mem[32'h00010008] = 32'h00040FFE;
    mem[32'h00020014] = 32'hABCDE001;
    mem[32'h00020FFC] = 32'h12345FFF;
    mem[32'h00020018] = 32'h55555FFE;
    mem[32'h00030000] = 32'hFFFFF001;
    mem[32'h00050000] = 32'h00020001;

    repeat (3) @(negedge clk);
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 done", {31'h0, done}, 0);
    chk("R1 fault", {31'h0, fault}, 0);
    chk("R1 mem_req", {31'h0, mem_req}, 0);
    chk("R1 fault_lvl", {30'h0, fault_lvl}, 0);
    chk("R1 pa", pa, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      glat = GL_T[i];
      rlat = RL_T[i];
      start(VA_T[i], RT_T[i]);
      wait_done(cyc);
      cyc++;
      chk("R4 done seen", {31'h0, done}, 1);
      check_walk(VA_T[i], RT_T[i], PA_T[i], FL_T[i], 0);
      if (glat == 0 && rlat == 0)
        chk("R9 cycles to done", cyc, FL_T[i] == 2'd1 ? 3 : 5);
      @(negedge clk);
      chk("R4 done one cycle", {31'h0, done}, 0);
    end

    glat = 1; rlat = 2;
    start(32'h00405123, 20'h00010);
    tr_req = 1'b1;
    tr_vaddr = 32'h007FFFFF;
    tr_root = 20'h00050;
    @(negedge clk);
    chk("R8 busy during walk", {31'h0, busy}, 1);
    tr_req = 1'b0;
    tr_vaddr = 32'hFFFFFFFF;
    tr_root = 20'hFFFFF;
    wait_done(cyc);
    check_walk(32'h00405123, 20'h00010, 32'hABCDE123, 2'd0, 0);
    chk("R8 reads for one walk", n_rd, 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 ignored request starts nothing", {30'h0, busy, mem_req}, 0);
    end

    glat = 0; rlat = 0;
    start(32'hFFC00000, 20'h00010);
    wait_done(cyc);
    chk("R8 busy in done cycle", {31'h0, busy}, 1);
    base = n_rd;
    tr_req = 1'b1;
    tr_vaddr = 32'h00005ABC;
    tr_root = 20'h00050;
    @(negedge clk);
    chk("R8 request in done cycle ignored", {31'h0, busy}, 0);
    @(negedge clk);
    chk("R8 request taken when idle", {31'h0, busy}, 1);
    tr_req = 1'b0;
    wait_done(cyc);
    cyc++;
    check_walk(32'h00005ABC, 20'h00050, 32'hABCDEABC, 2'd0, base);
    chk("R9 back-to-back cycles to done", cyc, 5);

    glat = 3; rlat = 0;
    start(32'h00405123, 20'h00010);
    repeat (2) begin
      @(negedge clk);
      chk("R7 request held before grant", {31'h0, mem_req}, 1);
      chk("R7 address held before grant", mem_addr, 32'h00010004);
    end
    wait_done(cyc);
    check_walk(32'h00405123, 20'h00010, 32'hABCDE123, 2'd0, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule